// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A bank of general-purpose pins, up to 64 wide, reached through a small register port in which every function occupies two 32-bit words. Software sets each pin as an input or an output, drives the output level, and reads back the level seen on the pin. The pin levels pass through a synchronizer before any logic uses them.

Every pin also watches for one edge, rising or falling, chosen by its own polarity bit. A detected edge sets that pin's status bit. Status bits set whether or not the pin's interrupt is enabled, and software clears them by writing ones. A single interrupt line is raised while any status bit is set and enabled. A separate wake line is raised while any status bit is set on a pin marked as a wake source. To catch both edges, software flips the polarity bit after each event.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads 0. All pins are inputs (`pin_oe` = 0), `pin_out` = 0, `irq` = 0, `wake` = 0, and every polarity selects a rising edge.
- R2: Pin n lives in word n/32, at bit n%32. The high word of each function is at the low word's offset + 4. Low-word offsets: input level 0x10, output level 0x18, output enable 0x20, status 0x40, interrupt enable 0x48, polarity 0x50, wake select 0x58.
- R3: `pin_oe[n]` equals output-enable bit n, and `pin_out[n]` equals output-level bit n. Both change only on a register write.
- R4: The input-level word returns the synchronized pin level whatever the direction of the pin. A pin change becomes readable after the synchronizer stages.
- R5: A polarity bit of 0 latches a rising edge (0 then 1) into status. A bit of 1 latches a falling edge. The opposite edge leaves status unchanged.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it as it was.
- R7: Status latches edges even while the interrupt enable is 0. `irq` is the OR over all pins of (status AND enable).
- R8: `wake` is the OR over all pins of (status AND wake select), independent of the interrupt enable.
- R9: An edge detected in the same cycle as a clear write to the same status bit wins, and the bit stays set.
- R10: A read request returns its data on `bus_rdata` with `bus_rvalid` high one cycle later. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| pin_in | input | NUM_PINS | Pin levels, asynchronous |
| pin_out | output | NUM_PINS | Output levels |
| pin_oe | output | NUM_PINS | Output enables, 1 = drive |
| irq | output | 1 | Combined enabled interrupt |
| wake | output | 1 | Combined wake request |

## Verification
An edge detected on a pin can land in the same cycle as a software write that clears that pin's status bit. The bench provokes this by first setting the bit with one rising edge and lowering the pin again. It then raises the pin once more and times the clear write so the register port samples it on the exact edge where the detector reports the new event. The status word read back afterwards must still hold the bit. A plain clear on another cycle must remove it, which shows the write itself did take effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int WORD_W = 32;

   localparam logic [7:0] OFS_IN   = 8'h10;
   localparam logic [7:0] OFS_OUT  = 8'h18;
   localparam logic [7:0] OFS_OE   = 8'h20;
   localparam logic [7:0] OFS_STAT = 8'h40;
   localparam logic [7:0] OFS_IEN  = 8'h48;
   localparam logic [7:0] OFS_POL  = 8'h50;
   localparam logic [7:0] OFS_WAKE = 8'h58;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_IN, SEL_OUT, SEL_OE, SEL_STAT, SEL_IEN, SEL_POL, SEL_WAKE
   } reg_sel_e;

   typedef struct packed {
      reg_sel_e sel;
      logic     hi;
   } reg_hit_t;

   // bit 2 picks the word, the remaining bits pick the function
   function automatic reg_hit_t decode_addr(input logic [7:0] a);
      reg_hit_t r;
      r.hi  = a[2];
      r.sel = SEL_NONE;
      if (a[1:0] == 2'b00) begin
         case ({a[7:3], 3'b000})
            OFS_IN:   r.sel = SEL_IN;
            OFS_OUT:  r.sel = SEL_OUT;
            OFS_OE:   r.sel = SEL_OE;
            OFS_STAT: r.sel = SEL_STAT;
            OFS_IEN:  r.sel = SEL_IEN;
            OFS_POL:  r.sel = SEL_POL;
            OFS_WAKE: r.sel = SEL_WAKE;
            default:  r.sel = SEL_NONE;
         endcase
      end
      return r;
   endfunction

   // mask of implemented pins inside word w
   function automatic logic [WORD_W-1:0] word_mask(input int num_pins, input int w);
      int left;
      left = num_pins - w * WORD_W;
      if (left >= WORD_W) return '1;
      if (left <= 0) return '0;
      return (32'h1 << left) - 32'h1;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int N      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] lvl_o,
   output logic [N-1:0] lvl_prev_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [N-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign lvl_o      = stage_q[STAGES-1];
   assign lvl_prev_o = prev_q;

endmodule

// File: rtl/gpio_irq_word.sv
module gpio_irq_word #(
   parameter int          W          = 32,
   parameter logic [31:0] VALID_MASK = 32'hFFFF_FFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] lvl_prev_i,
   input  logic         wr_stat_i,
   input  logic         wr_ien_i,
   input  logic         wr_pol_i,
   input  logic         wr_wake_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] status_o,
   output logic [W-1:0] ien_o,
   output logic [W-1:0] pol_o,
   output logic [W-1:0] wake_sel_o,
   output logic         irq_o,
   output logic         wake_o
);

   generate
      if (W != 32) begin : g_bad_width
         $error("gpio_irq_word: W must be 32");
      end
      if (VALID_MASK == 32'h0) begin : g_bad_mask
         $error("gpio_irq_word: word has no pins");
      end
   endgenerate

   localparam logic [W-1:0] VM = VALID_MASK[W-1:0];

   logic [W-1:0] status_q, ien_q, pol_q, wake_q;
   logic [W-1:0] rise, fall, hit, clr;

   assign rise = lvl_i & ~lvl_prev_i;
   assign fall = ~lvl_i & lvl_prev_i;
   assign hit  = ((rise & ~pol_q) | (fall & pol_q)) & VM;
   assign clr  = wr_stat_i ? wdata_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         ien_q    <= '0;
         pol_q    <= '0;
         wake_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr) | hit;
         if (wr_ien_i)  ien_q  <= wdata_i & VM;
         if (wr_pol_i)  pol_q  <= wdata_i & VM;
         if (wr_wake_i) wake_q <= wdata_i & VM;
      end
   end

   assign status_o   = status_q;
   assign ien_o      = ien_q;
   assign pol_o      = pol_q;
   assign wake_sel_o = wake_q;
   assign irq_o      = |(status_q & ien_q);
   assign wake_o     = |(status_q & wake_q);

   // R6
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat_i |=> ((status_q & $past(wdata_i) & ~$past(hit)) == '0))
      else $error("status bit not cleared by write of one");

   // R9
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> ((status_q & $past(hit)) == $past(hit)))
      else $error("detected edge lost");

   // R5
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(hit)) == '0))
      else $error("status bit set without a qualified edge");

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
   parameter int NUM_PINS    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [7:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                bus_rvalid,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic                irq,
   output logic                wake
);
   import gpio_bank_pkg::*;

   localparam int NW   = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int PADW = NW * WORD_W;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
         $error("gpio_edge_bank: NUM_PINS must lie in 1..64");
      end
   endgenerate

   // synchronized pin levels
   logic [NUM_PINS-1:0] lvl, lvl_prev;

   gpio_in_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_i      (pin_in),
      .lvl_o      (lvl),
      .lvl_prev_o (lvl_prev)
   );

   logic [NW-1:0][WORD_W-1:0] lvl_pad, prev_pad;
   assign lvl_pad  = PADW'(lvl);
   assign prev_pad = PADW'(lvl_prev);

   // register port decode
   reg_hit_t acc;
   logic     wr_go, rd_go;
   assign acc   = decode_addr(bus_addr);
   assign wr_go = bus_sel & bus_wr;
   assign rd_go = bus_sel & ~bus_wr;

   // output level and enable registers
   logic [NW-1:0][WORD_W-1:0] out_q, oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= '0;
      end else if (wr_go) begin
         for (int w = 0; w < NW; w++) begin
            if (acc.hi == 1'(w)) begin
               if (acc.sel == SEL_OUT) out_q[w] <= bus_wdata & word_mask(NUM_PINS, w);
               if (acc.sel == SEL_OE)  oe_q[w]  <= bus_wdata & word_mask(NUM_PINS, w);
            end
         end
      end
   end

   assign pin_out = NUM_PINS'(out_q);
   assign pin_oe  = NUM_PINS'(oe_q);

   // interrupt words
   logic [WORD_W-1:0] stat_w [NW];
   logic [WORD_W-1:0] ien_w  [NW];
   logic [WORD_W-1:0] pol_w  [NW];
   logic [WORD_W-1:0] wsel_w [NW];
   logic              irq_w  [NW];
   logic              wake_w [NW];

   generate
      for (genvar w = 0; w < NW; w++) begin : g_word
         logic here;
         assign here = wr_go && (acc.hi == 1'(w));

         gpio_irq_word #(
            .W          (WORD_W),
            .VALID_MASK (word_mask(NUM_PINS, w))
         ) u_word (
            .clk        (clk),
            .rst_n      (rst_n),
            .lvl_i      (lvl_pad[w]),
            .lvl_prev_i (prev_pad[w]),
            .wr_stat_i  (here && acc.sel == SEL_STAT),
            .wr_ien_i   (here && acc.sel == SEL_IEN),
            .wr_pol_i   (here && acc.sel == SEL_POL),
            .wr_wake_i  (here && acc.sel == SEL_WAKE),
            .wdata_i    (bus_wdata),
            .status_o   (stat_w[w]),
            .ien_o      (ien_w[w]),
            .pol_o      (pol_w[w]),
            .wake_sel_o (wsel_w[w]),
            .irq_o      (irq_w[w]),
            .wake_o     (wake_w[w])
         );
      end
   endgenerate

   always_comb begin
      irq  = 1'b0;
      wake = 1'b0;
      for (int w = 0; w < NW; w++) begin
         irq  = irq  | irq_w[w];
         wake = wake | wake_w[w];
      end
   end

   // read path, one register stage
   logic [WORD_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int w = 0; w < NW; w++) begin
         if (acc.hi == 1'(w)) begin
            case (acc.sel)
               SEL_IN:   rd_next = lvl_pad[w];
               SEL_OUT:  rd_next = out_q[w];
               SEL_OE:   rd_next = oe_q[w];
               SEL_STAT: rd_next = stat_w[w];
               SEL_IEN:  rd_next = ien_w[w];
               SEL_POL:  rd_next = pol_w[w];
               SEL_WAKE: rd_next = wsel_w[w];
               default:  rd_next = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_go;
         if (rd_go) bus_rdata <= rd_next;
      end
   end

   // R10
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr) |=> bus_rvalid)
      else $error("read request without data valid");

   // R10
   rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_sel && !bus_wr))
      else $error("data valid without read request");

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)))
      else $error("pin drive changed without a write");

endmodule

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;

   localparam int NP = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic [NP-1:0] pins = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic          irq, wake;

   always #2.5 clk = ~clk;

   gpio_edge_bank #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .pin_in(pins), .pin_out(pin_out),
      .pin_oe(pin_oe), .irq(irq), .wake(wake)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   // driver: issues a read and pushes the expected word
   task automatic reg_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic set_pin(input int i, input logic v);
      @(negedge clk);
      pins[i] = v;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   // monitor: pops expected words as read data appears
   always @(negedge clk) begin
      if (bus_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R10: unexpected read data %h expected none", bus_rdata);
         end else begin
            check({32'h0, bus_rdata}, {32'h0, exp_q.pop_front()}, tag_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check({63'h0, irq}, 64'h0, "R1 irq");
      check({63'h0, wake}, 64'h0, "R1 wake");
      check(pin_oe, 64'h0, "R1 pin_oe");
      check(pin_out, 64'h0, "R1 pin_out");
      reg_rd(8'h20, 32'h0, "R1 oe lo");
      reg_rd(8'h40, 32'h0, "R1 status lo");
      reg_rd(8'h54, 32'h0, "R1 polarity hi");

      // R3 / R2 drive registers and word mapping
      reg_wr(8'h18, 32'hA5A5_0003);
      reg_wr(8'h1C, 32'h1234_5678);
      reg_wr(8'h20, 32'h0000_FFFF);
      reg_wr(8'h24, 32'h8000_0000);
      @(negedge clk);
      check(pin_out, 64'h1234_5678_A5A5_0003, "R3 pin_out");
      check(pin_oe, 64'h8000_0000_0000_FFFF, "R2 pin_oe hi word");
      reg_rd(8'h1C, 32'h1234_5678, "R2 out hi readback");
      reg_rd(8'h24, 32'h8000_0000, "R10 oe hi readback");

      // R4 input level regardless of direction, R7 latch while disabled
      @(negedge clk);
      pins = 64'h8000_0001_0000_0003;
      settle();
      reg_rd(8'h10, 32'h0000_0003, "R4 in lo");
      reg_rd(8'h14, 32'h8000_0001, "R4 in hi");
      reg_rd(8'h40, 32'h0000_0003, "R7 status lo latched");
      reg_rd(8'h44, 32'h8000_0001, "R7 status hi latched");
      check({63'h0, irq}, 64'h0, "R7 irq disabled");

      // R7 enable gates irq
      reg_wr(8'h4C, 32'h8000_0000);
      @(negedge clk);
      check({63'h0, irq}, 64'h1, "R7 irq enabled");

      // R6 write one to clear, zero leaves
      reg_wr(8'h44, 32'h0000_0001);
      reg_rd(8'h44, 32'h8000_0000, "R6 partial clear");
      check({63'h0, irq}, 64'h1, "R6 irq still pending");
      reg_wr(8'h44, 32'h8000_0000);
      @(negedge clk);
      check({63'h0, irq}, 64'h0, "R6 irq after clear");
      reg_wr(8'h40, 32'h0000_0000);
      reg_rd(8'h40, 32'h0000_0003, "R6 zero write leaves");
      reg_wr(8'h40, 32'h0000_0003);
      reg_rd(8'h40, 32'h0000_0000, "R6 lo cleared");

      // R5 falling polarity on pin 4, rising on pin 5
      reg_wr(8'h50, 32'h0000_0010);
      set_pin(4, 1'b1); settle();
      reg_rd(8'h40, 32'h0000_0000, "R5 falling ignores rise");
      set_pin(4, 1'b0); settle();
      reg_rd(8'h40, 32'h0000_0010, "R5 falling edge latched");
      set_pin(5, 1'b1); settle();
      reg_rd(8'h40, 32'h0000_0030, "R5 rising edge latched");
      reg_wr(8'h40, 32'h0000_0020);
      set_pin(5, 1'b0); settle();
      reg_rd(8'h40, 32'h0000_0010, "R5 rising ignores fall");

      // R8 wake follows status and wake select, not enable
      check({63'h0, wake}, 64'h0, "R8 wake unselected");
      reg_wr(8'h58, 32'h0000_0010);
      @(negedge clk);
      check({63'h0, wake}, 64'h1, "R8 wake raised");
      check({63'h0, irq}, 64'h0, "R8 irq stays low");
      reg_wr(8'h40, 32'h0000_0010);
      @(negedge clk);
      check({63'h0, wake}, 64'h0, "R8 wake after clear");

      // R9 edge and clear in the same cycle
      set_pin(6, 1'b1); settle();
      set_pin(6, 1'b0); settle();
      reg_rd(8'h40, 32'h0000_0040, "R9 setup");
      set_pin(6, 1'b1);
      @(negedge clk);
      reg_wr(8'h40, 32'h0000_0040);
      reg_rd(8'h40, 32'h0000_0040, "R9 edge wins over clear");
      reg_wr(8'h40, 32'h0000_0040);
      reg_rd(8'h40, 32'h0000_0000, "R9 plain clear");

      // R10 unmapped offsets
      reg_rd(8'h30, 32'h0, "R10 unmapped");
      reg_rd(8'h12, 32'h0, "R10 misaligned");

      repeat (3) @(negedge clk);
      check(exp_q.size(), 64'h0, "R10 all reads answered");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule